// File: doc/BRIEF.md
# SPI Master with Interval Auto-Repeat

This block is a register-programmed SPI master that shifts 2 to 16 bits per exchange in clock mode 0: SCLK idles low, MOSI changes on the falling edge and MISO is sampled on the rising edge. Software programs the exchange length, writes transmit data and sets the exchange-start bit. The block drives SCLK, MOSI and an active-low chip select. When the exchange ends it returns the received word and pulses a completion flag.

An internal loopback path feeds the outgoing bit stream back to the receiver in place of the MISO pin, so software can test the shift path on its own. In interval mode, which needs the master bit, each completed exchange loads an interval count into a down-counter. That counter steps once per bit-clock period, and when it runs out the next exchange begins with the data register as it is at that moment.

The bit clock comes from the system clock. One SCLK period lasts `2*HALF_DIV` system clocks. The register port has four word addresses: 0 for control, 1 for interval control, 2 for data (write transmit, read receive) and 3, which reads zero.

Top module: `spi_ivl_master`

## Requirements
- R1: After reset every register reads 0, `cs_no` is high, and `sclk_o`, `mosi_o` and `done_o` are low.
- R2: Control bits [3:0] hold a length code k. A code from 1 to 15 gives k+1 SCLK pulses while `cs_no` is low, so 0001 gives 2 bits, 0111 gives 8 bits and 1111 gives 16 bits.
- R3: MOSI sends transmit bits from bit k down to bit 0, one per SCLK period. It changes only while SCLK is low, and SCLK stays low whenever `cs_no` is high.
- R4: The received word (read at address 2) is right-justified, with the first sampled bit at position k and every bit above k cleared.
- R5: With interval-control bit 14 set (loopback), the received word equals the transmitted word masked to k+1 bits, and `miso_i` has no effect.
- R6: A length code of 0 disables the engine. Writing the exchange-start bit does nothing, `cs_no` stays high and control bit 5 reads 0.
- R7: Writing 1 to control bit 5 (exchange start) while control bit 4 (master) is set and the code is nonzero starts one exchange. Bit 5 reads 1 until the exchange ends, and `done_o` is high for exactly one clock at the end.
- R8: With interval-control bit 13 set and master set, each finished exchange starts the next one after max(N,1) whole bit periods, where N is interval-control bits [IVL_W-1:0] (default bits [11:0]). The gap runs from `cs_no` rising to `cs_no` falling.
- R9: Each automatic exchange sends the data register contents as they are when that exchange starts.
- R10: With master clear, neither interval mode nor the exchange-start bit starts an exchange.
- R11: Interval-control bit 15 and bits 12 down to IVL_W are reserved. They read 0 and ignore writes.
- R12: Clearing interval-control bit 13 stops the automatic repeats once the current exchange has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Chip select, active low |
| done_o | output | 1 | One-cycle pulse when an exchange ends |

## Verification
A shift register or bit counter in the wrong state shows up within the same exchange. The SCLK pulse count taken while `cs_no` is low, the MOSI stream captured on each rising edge and the received word read at the `done_o` pulse would each be wrong. An interval counter that loads or steps at the wrong moment moves the next falling edge of `cs_no` by whole bit periods, so the gap is measured in clocks from one exchange to the next. A stuck start or enable state appears as chip-select activity that should not happen during a quiet window, or as a start bit that does not clear when the exchange ends.

// File: rtl/spi_ivl_pkg.sv
package spi_ivl_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LEN_W  = 4;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_IVL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  localparam int unsigned B_MASTER = 4;
  localparam int unsigned B_GO     = 5;
  localparam int unsigned B_IVL_EN = 13;
  localparam int unsigned B_LOOP   = 14;

  typedef struct packed {
    logic [LEN_W-1:0] len_code;
    logic             master;
    logic             loop;
    logic             ivl_en;
  } cfg_t;
endpackage

// File: rtl/spi_ivl_bitclk.sv
module spi_ivl_bitclk #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rise_tick_o,
  output logic bit_tick_o
);
  localparam int unsigned BIT_CYC = 2 * HALF_DIV;
  localparam int unsigned CW      = $clog2(BIT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (cnt_q == CW'(BIT_CYC - 1))       cnt_q <= '0;
    else                                      cnt_q <= cnt_q + CW'(1);
  end

  assign rise_tick_o = (cnt_q == CW'(HALF_DIV - 1));
  assign bit_tick_o  = (cnt_q == CW'(BIT_CYC - 1));
endmodule

// File: rtl/spi_ivl_shift.sv
module spi_ivl_shift
  import spi_ivl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_tick_i,
  input  logic              bit_tick_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_code_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              loop_i,
  input  logic              miso_i,
  output logic              active_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [DATA_W-1:0] sh_q, rx_sh_q, rx_q;
  logic [LEN_W-1:0]  left_q, sh_amt;
  logic              active_q, sclk_q, rx_bit;

  assign sh_amt = LEN_W'(DATA_W - 1) - len_code_i;
  assign mosi_o = active_q & sh_q[DATA_W-1];
  // loopback feeds the outgoing bit straight back to the receiver
  assign rx_bit = loop_i ? mosi_o : miso_i;
  assign fin_o  = active_q & bit_tick_i & (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      rx_sh_q  <= '0;
      rx_q     <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
    end else if (start_i) begin
      sh_q     <= tx_i << sh_amt;
      rx_sh_q  <= '0;
      left_q   <= len_code_i;
      active_q <= 1'b1;
      sclk_q   <= 1'b0;
    end else if (active_q) begin
      if (rise_tick_i) begin
        sclk_q  <= 1'b1;
        rx_sh_q <= {rx_sh_q[DATA_W-2:0], rx_bit};
      end
      if (bit_tick_i) begin
        sclk_q <= 1'b0;
        if (left_q == '0) begin
          active_q <= 1'b0;
          rx_q     <= rx_sh_q;
        end else begin
          sh_q   <= sh_q << 1;
          left_q <= left_q - LEN_W'(1);
        end
      end
    end
  end

  assign active_o = active_q;
  assign sclk_o   = sclk_q;
  assign rx_o     = rx_q;
endmodule

// File: rtl/spi_ivl_timer.sv
module spi_ivl_timer #(
  parameter int unsigned IVL_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ivl_act_i,
  input  logic             fin_i,
  input  logic             start_i,
  input  logic             bit_tick_i,
  input  logic [IVL_W-1:0] reload_i,
  output logic             fire_o
);
  logic [IVL_W-1:0] cnt_q;
  logic             armed_q;

  // a count of 0 or 1 expires on the first bit-period boundary
  assign fire_o = armed_q & ivl_act_i & bit_tick_i & (cnt_q <= IVL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (fin_i && ivl_act_i) begin
      cnt_q   <= reload_i;
      armed_q <= 1'b1;
    end else if (!ivl_act_i || start_i || fire_o) begin
      armed_q <= 1'b0;
    end else if (armed_q && bit_tick_i) begin
      cnt_q <= cnt_q - IVL_W'(1);
    end
  end
endmodule

// File: rtl/spi_ivl_regs.sv
module spi_ivl_regs
  import spi_ivl_pkg::*;
#(
  parameter int unsigned IVL_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] rx_i,
  input  logic              fin_i,
  input  logic              fire_i,
  output cfg_t              cfg_o,
  output logic [IVL_W-1:0]  ivl_cnt_o,
  output logic [DATA_W-1:0] tx_o,
  output logic              xch_o
);
  cfg_t              cfg_q;
  logic [IVL_W-1:0]  ivl_q;
  logic [DATA_W-1:0] tx_q;
  logic              xch_q, sw_go, unused_w;

  assign unused_w = ^wdata_i;
  // start honoured only when the same write leaves the engine enabled
  assign sw_go = we_i && (addr_i == A_CTRL) && wdata_i[B_GO] &&
                 wdata_i[B_MASTER] && (wdata_i[LEN_W-1:0] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ivl_q <= '0;
      tx_q  <= '0;
      xch_q <= 1'b0;
    end else begin
      if (we_i) begin
        case (addr_i)
          A_CTRL: begin
            cfg_q.len_code <= wdata_i[LEN_W-1:0];
            cfg_q.master   <= wdata_i[B_MASTER];
          end
          A_IVL: begin
            cfg_q.loop   <= wdata_i[B_LOOP];
            cfg_q.ivl_en <= wdata_i[B_IVL_EN];
            ivl_q        <= wdata_i[IVL_W-1:0];
          end
          A_DATA:  tx_q <= wdata_i;
          default: ;
        endcase
      end
      if (fin_i)                xch_q <= 1'b0;
      else if (fire_i || sw_go) xch_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[LEN_W-1:0] = cfg_q.len_code;
        rdata_o[B_MASTER]  = cfg_q.master;
        rdata_o[B_GO]      = xch_q;
      end
      A_IVL: begin
        rdata_o[IVL_W-1:0] = ivl_q;
        rdata_o[B_IVL_EN]  = cfg_q.ivl_en;
        rdata_o[B_LOOP]    = cfg_q.loop;
      end
      A_DATA:  rdata_o = rx_i;
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o     = cfg_q;
  assign ivl_cnt_o = ivl_q;
  assign tx_o      = tx_q;
  assign xch_o     = xch_q;
endmodule

// File: rtl/spi_ivl_master.sv
module spi_ivl_master
  import spi_ivl_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned IVL_W    = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_no,
  output logic        done_o
);
  cfg_t              cfg;
  logic [IVL_W-1:0]  ivl_cnt;
  logic [DATA_W-1:0] tx_data, rx_data;
  logic              xch_q, fire, fin, active, start, eng_en, ivl_act;
  logic              rise_tick, bit_tick, done_q;

  assign eng_en  = cfg.master & (cfg.len_code != '0);
  assign ivl_act = eng_en & cfg.ivl_en;
  assign start   = bit_tick & ~active & eng_en & (xch_q | fire);

  spi_ivl_regs #(.IVL_W(IVL_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .rx_i(rx_data), .fin_i(fin), .fire_i(fire),
    .cfg_o(cfg), .ivl_cnt_o(ivl_cnt), .tx_o(tx_data), .xch_o(xch_q)
  );

  spi_ivl_bitclk #(.HALF_DIV(HALF_DIV)) i_bitclk (
    .clk_i, .rst_ni, .rise_tick_o(rise_tick), .bit_tick_o(bit_tick)
  );

  spi_ivl_shift i_shift (
    .clk_i, .rst_ni,
    .rise_tick_i(rise_tick), .bit_tick_i(bit_tick), .start_i(start),
    .len_code_i(cfg.len_code), .tx_i(tx_data), .loop_i(cfg.loop),
    .miso_i(miso_i), .active_o(active), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .fin_o(fin), .rx_o(rx_data)
  );

  spi_ivl_timer #(.IVL_W(IVL_W)) i_timer (
    .clk_i, .rst_ni,
    .ivl_act_i(ivl_act), .fin_i(fin), .start_i(start),
    .bit_tick_i(bit_tick), .reload_i(ivl_cnt), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= fin;
  end

  assign done_o = done_q;
  assign cs_no  = ~active;
endmodule

// File: rtl/spi_ivl_chk.sv
module spi_ivl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o,
  input logic done_o,
  input logic en_i,
  input logic xch_i
);
  p_sclk_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_mosi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(mosi_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_go_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !xch_i);

  // covers R6 and R10: no enable, no new chip-select activity
  p_no_start_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && cs_no) |=> cs_no);
endmodule

bind spi_ivl_master spi_ivl_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_no(cs_no), .sclk_o(sclk_o),
  .mosi_o(mosi_o), .done_o(done_o), .en_i(eng_en), .xch_i(xch_q)
);

// File: tb/test_spi_ivl_master.sv
module test_spi_ivl_master;
  localparam int HALF_DIV = 2;
  localparam int BIT_P    = 2 * HALF_DIV;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [15:0] reg_wdata_i = 16'h0;
  logic [15:0] reg_rdata_o;
  logic        sclk_o, mosi_o, cs_no, done_o;
  logic        miso_i = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  spi_ivl_master #(.HALF_DIV(HALF_DIV), .IVL_W(12)) i_spi_ivl_master (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .sclk_o, .mosi_o, .miso_i, .cs_no, .done_o
  );

  // bus monitor: MOSI captured on each SCLK rise, cleared at chip-select fall
  logic        cs_d = 1'b1, sclk_d = 1'b0;
  logic [15:0] cap = '0;
  int          edges = 0;
  always @(posedge clk_i) begin
    cs_d   <= cs_no;
    sclk_d <= sclk_o;
    if (cs_d && !cs_no) begin
      cap   <= '0;
      edges <= 0;
    end else if (!cs_no && sclk_o && !sclk_d) begin
      cap   <= {cap[14:0], mosi_o};
      edges <= edges + 1;
    end
  end

  // {len_code, loopback, miso level, tx}
  localparam logic [21:0] VEC [8] = '{
    {4'd1,  1'b1, 1'b0, 16'hFFFE},
    {4'd7,  1'b0, 1'b1, 16'h00A5},
    {4'd15, 1'b1, 1'b0, 16'hC3A5},
    {4'd15, 1'b0, 1'b0, 16'h8001},
    {4'd3,  1'b1, 1'b1, 16'h1236},
    {4'd11, 1'b0, 1'b1, 16'hF5A5},
    {4'd4,  1'b1, 1'b1, 16'h0011},
    {4'd8,  1'b1, 1'b0, 16'hFF00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic gap_clocks(output int k);
    k = 0;
    while (cs_no) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  task automatic quiet(input int n, output bit stayed);
    stayed = 1'b1;
    for (int j = 0; j < n; j++) begin
      @(negedge clk_i);
      if (!cs_no || sclk_o) stayed = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int k;
    bit ok;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    rd(2'd0, r); chk(r == 16'h0, "R1 ctrl", r, 0);
    rd(2'd1, r); chk(r == 16'h0, "R1 ivl", r, 0);
    rd(2'd2, r); chk(r == 16'h0, "R1 data", r, 0);
    chk(cs_no && !sclk_o && !mosi_o && !done_o, "R1 pins",
        {cs_no, sclk_o, mosi_o, done_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 8; i++) begin
      logic [21:0] v;
      logic [3:0]  lc;
      logic [16:0] m;
      logic [15:0] tx, exp_rx;
      logic        lp, mi;
      v = VEC[i];
      lc = v[21:18]; lp = v[17]; mi = v[16]; tx = v[15:0];
      m = (17'd1 << (lc + 1)) - 17'd1;
      exp_rx = lp ? (tx & m[15:0]) : (mi ? m[15:0] : 16'h0);
      miso_i = mi;
      wr(2'd1, {1'b0, lp, 14'h0});
      wr(2'd2, tx);
      wr(2'd0, {10'h0, 1'b1, 1'b1, lc});
      rd(2'd0, r);
      chk(r[5] == 1'b1, "R7 go busy", r[5], 1);
      wait_done();
      rd(2'd0, r);
      chk(r[5] == 1'b0, "R7 go cleared", r[5], 0);
      rd(2'd2, r);
      chk(r == exp_rx, lp ? "R5 loopback rx" : "R4 rx justify", r, exp_rx);
      chk(edges == int'(lc) + 1, "R2 sclk pulses", edges, lc + 1);
      chk(cap == (tx & m[15:0]), "R3 mosi order", cap, tx & m[15:0]);
      @(negedge clk_i);
      chk(!done_o, "R7 done one cycle", done_o, 0);
    end
    miso_i = 1'b0;

    // R11 reserved bits
    wr(2'd0, 16'h0);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, r); chk(r == 16'h6FFF, "R11 reserved", r, 16'h6FFF);
    wr(2'd1, 16'h0);

    // R6 length code 0 blocks start
    wr(2'd0, 16'h0030);
    quiet(60, ok); chk(ok, "R6 no activity", ok, 1);
    rd(2'd0, r); chk(r == 16'h0010, "R6 go ignored", r, 16'h0010);

    // R10 slave: interval and start ignored
    wr(2'd0, 16'h0007);
    wr(2'd1, 16'h6001);
    wr(2'd0, 16'h0027);
    quiet(60, ok); chk(ok, "R10 no activity", ok, 1);
    rd(2'd0, r); chk(r == 16'h0007, "R10 go ignored", r, 16'h0007);

    // R8/R9 interval mode, 4-bit loopback exchanges
    wr(2'd1, 16'h6003);
    wr(2'd2, 16'h000A);
    wr(2'd0, 16'h0033);
    wait_done();
    gap_clocks(k); chk(k == 3 * BIT_P, "R8 gap N=3", k, 3 * BIT_P);
    wr(2'd2, 16'h0005);
    wait_done();
    rd(2'd2, r); chk(r == 16'h000A, "R9 data at start", r, 16'h000A);
    wr(2'd1, 16'h6000);
    wait_done();
    gap_clocks(k); chk(k == BIT_P, "R8 gap N=0", k, BIT_P);
    rd(2'd2, r); chk(r == 16'h0005, "R9 new data", r, 16'h0005);

    // R12 leaving interval mode stops repeats
    wr(2'd1, 16'h4000);
    repeat (40) @(negedge clk_i);
    quiet(60, ok); chk(ok, "R12 repeats stop", ok, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule